// File: doc/BRIEF.md
# SD Card SPI Command Issuer

This block sends one SD-card command over SPI and collects the card's one-byte status reply. It takes a 6-bit command index, a 32-bit argument and an optional replacement check byte. It builds the six-byte command frame and passes it a byte at a time to an external byte-wide SPI shifter. It then clocks filler bytes until the card answers. The block drives the card's chip-select line for the whole exchange. The caller receives the status byte and a completion pulse, or a timeout flag when the card never answers.

Most commands end the normal way: chip-select is released and one idle byte is clocked so that the card frees its output. Some commands are followed by a data phase in the same transaction, for example a register read. For these the caller sets hold mode. After a good reply, chip-select then stays low until the caller ends the hold or issues another command. A timeout always releases the card, whichever mode is set.

The shifter interface is a plain request/acknowledge pair. The block raises `xfer_req` with the byte to send on `xfer_tx` and holds both steady. The shifter pulses `xfer_ack` for one cycle together with the byte it received on `xfer_rx`.

Top module: `sd_cmd_issuer`

## Requirements
- R1: The first byte of a frame is the command index in bits 5:0 with bits 7:6 set to 01, i.e. 0x40 OR index.
- R2: Frame bytes two to five carry the argument, most significant byte first. `xfer_tx` stays unchanged while `xfer_req` is high and no acknowledge has come.
- R3: The sixth frame byte is 0x95 when `crc_sel` is low and `crc_val` when `crc_sel` is high.
- R4: `cs_n` goes low at least one cycle before the first frame byte is requested, and it stays low through the frame and the poll.
- R5: After the frame the block sends 0xFF bytes. The first received byte with bit 7 equal to 0 ends the poll and is returned on `resp`, with `timed_out` low. The status bits are, from bit 0 up: idle, erase reset, illegal command, command check error, erase sequence error, address error, parameter error.
- R6: If `POLL_LIMIT` (default 5000) polled bytes all have bit 7 set, the block stops polling and reports `timed_out` high.
- R7: In normal mode, once a reply arrives or the poll times out, `cs_n` rises and exactly one more 0xFF byte is sent with `cs_n` high. `done` pulses after that byte completes.
- R8: In hold mode with a valid reply, no idle byte is sent. `done` pulses, `cs_n` stays low and `busy` is low. A `hold_end` pulse then releases `cs_n`, sends one 0xFF byte and pulses `done` again.
- R9: In hold mode, a timeout still releases `cs_n` and sends the single 0xFF idle byte.
- R10: A `cmd_req` that arrives while `busy` is high is ignored.
- R11: After reset `cs_n` is high and `xfer_req`, `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_req | input | 1 | Start a command (accepted when not busy) |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| crc_sel | input | 1 | Use `crc_val` as the sixth byte |
| crc_val | input | 8 | Replacement sixth byte |
| hold_sel | input | 1 | Keep chip-select low after a valid reply |
| hold_end | input | 1 | End a held transaction |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| resp | output | 8 | Last status byte received |
| timed_out | output | 1 | No valid reply within the poll limit |
| cs_n | output | 1 | Card chip-select, active low |
| xfer_req | output | 1 | Byte transfer request to the shifter |
| xfer_tx | output | 8 | Byte to send |
| xfer_ack | input | 1 | Shifter finished the byte |
| xfer_rx | input | 8 | Byte received, valid with `xfer_ack` |

## Verification
The hardest case to reach is the poll limit. It needs an emulated card that answers every one of thousands of polled bytes with bit 7 set, and the exact number of filler bytes is only visible as a count at the byte port. The bench card model can be told to never reply. The scoreboard queues one expected item per polled byte plus the idle byte, so one extra or one missing poll shows up as a mismatch. The held-select case is driven the same way, followed by an idle stretch in which any unexpected byte at the port is reported.

// File: rtl/sd_cmd_issuer.sv
module sd_cmd_issuer #(
  parameter int          POLL_LIMIT  = 5000,
  parameter logic [7:0]  CRC_DEFAULT = 8'h95,
  parameter logic [7:0]  FILL_BYTE   = 8'hFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_req,
  input  logic [5:0]  cmd_idx,
  input  logic [31:0] cmd_arg,
  input  logic        crc_sel,
  input  logic [7:0]  crc_val,
  input  logic        hold_sel,
  input  logic        hold_end,
  output logic        busy,
  output logic        done,
  output logic [7:0]  resp,
  output logic        timed_out,
  output logic        cs_n,
  output logic        xfer_req,
  output logic [7:0]  xfer_tx,
  input  logic        xfer_ack,
  input  logic [7:0]  xfer_rx
);
  localparam int CW = $clog2(POLL_LIMIT + 1);

  typedef enum logic [2:0] {S_IDLE, S_PREP, S_SEND, S_POLL, S_TAIL, S_HELD} st_t;

  st_t         st;
  logic [2:0]  bidx;
  logic [CW-1:0] pcnt;
  logic [5:0]  idx_q;
  logic [31:0] arg_q;
  logic [7:0]  crc_q;
  logic        hold_q;
  logic        accept;

  assign accept   = cmd_req && (st == S_IDLE || st == S_HELD);
  assign busy     = !(st == S_IDLE || st == S_HELD);
  assign xfer_req = (st == S_SEND) || (st == S_POLL) || (st == S_TAIL);
  assign cs_n     = !(st == S_PREP || st == S_SEND || st == S_POLL || st == S_HELD);

  always_comb begin
    xfer_tx = FILL_BYTE;
    if (st == S_SEND) begin
      case (bidx)
        3'd0:    xfer_tx = {2'b01, idx_q};
        3'd1:    xfer_tx = arg_q[31:24];
        3'd2:    xfer_tx = arg_q[23:16];
        3'd3:    xfer_tx = arg_q[15:8];
        3'd4:    xfer_tx = arg_q[7:0];
        default: xfer_tx = crc_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      bidx      <= '0;
      pcnt      <= '0;
      idx_q     <= '0;
      arg_q     <= '0;
      crc_q     <= CRC_DEFAULT;
      hold_q    <= 1'b0;
      resp      <= FILL_BYTE;
      timed_out <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE, S_HELD: begin
          if (accept) begin
            idx_q     <= cmd_idx;
            arg_q     <= cmd_arg;
            crc_q     <= crc_sel ? crc_val : CRC_DEFAULT;
            hold_q    <= hold_sel;
            timed_out <= 1'b0;
            st        <= S_PREP;
          end else if (st == S_HELD && hold_end) begin
            st <= S_TAIL;
          end
        end
        S_PREP: begin
          bidx <= '0;
          st   <= S_SEND;
        end
        S_SEND: if (xfer_ack) begin
          if (bidx == 3'd5) begin
            pcnt <= '0;
            st   <= S_POLL;
          end else begin
            bidx <= bidx + 3'd1;
          end
        end
        S_POLL: if (xfer_ack) begin
          resp <= xfer_rx;
          if (!xfer_rx[7]) begin
            if (hold_q) begin
              st   <= S_HELD;
              done <= 1'b1;
            end else begin
              st <= S_TAIL;
            end
          end else if (pcnt == CW'(POLL_LIMIT - 1)) begin
            timed_out <= 1'b1;
            st        <= S_TAIL;
          end else begin
            pcnt <= pcnt + 1'b1;
          end
        end
        S_TAIL: if (xfer_ack) begin
          st   <= S_IDLE;
          done <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module sd_cmd_issuer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic [7:0] resp,
  input logic       timed_out,
  input logic       cs_n,
  input logic       xfer_req,
  input logic [7:0] xfer_tx,
  input logic       xfer_ack
);
  a_r4_sel_setup: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(xfer_req) && !cs_n) |-> $past(!cs_n));

  a_r2_byte_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && !xfer_ack) |=> (xfer_req && $stable(xfer_tx)));

  a_r7_tail_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req && cs_n) |-> (xfer_tx == 8'hFF));

  a_r9_timeout_release: assert property (@(posedge clk) disable iff (!rst_n)
    (done && timed_out) |-> cs_n);

  a_r5_reply_msb: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !timed_out) |-> !resp[7]);

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !xfer_req);
endmodule

bind sd_cmd_issuer sd_cmd_issuer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .resp(resp),
  .timed_out(timed_out), .cs_n(cs_n), .xfer_req(xfer_req),
  .xfer_tx(xfer_tx), .xfer_ack(xfer_ack)
);

// File: tb/sd_cmd_issuer_test.sv
`timescale 1ns/1ps
module sd_cmd_issuer_test;
  localparam int LIMIT = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_req = 1'b0;
  logic [5:0]  cmd_idx = '0;
  logic [31:0] cmd_arg = '0;
  logic        crc_sel = 1'b0;
  logic [7:0]  crc_val = '0;
  logic        hold_sel = 1'b0;
  logic        hold_end = 1'b0;
  logic        busy, done, timed_out, cs_n, xfer_req;
  logic [7:0]  resp, xfer_tx;
  logic        xfer_ack = 1'b0;
  logic [7:0]  xfer_rx = 8'hFF;

  int checks = 0;
  int errors = 0;
  logic [8:0] expq[$];
  string cur_tag = "R11";
  int ack_idx = 0;
  int card_dly = -1;
  logic [7:0] card_val = 8'h00;
  int wait_cnt = 0;

  always #4 clk = ~clk;

  sd_cmd_issuer uut (
    .clk(clk), .rst_n(rst_n), .cmd_req(cmd_req), .cmd_idx(cmd_idx),
    .cmd_arg(cmd_arg), .crc_sel(crc_sel), .crc_val(crc_val),
    .hold_sel(hold_sel), .hold_end(hold_end), .busy(busy), .done(done),
    .resp(resp), .timed_out(timed_out), .cs_n(cs_n), .xfer_req(xfer_req),
    .xfer_tx(xfer_tx), .xfer_ack(xfer_ack), .xfer_rx(xfer_rx)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // card model and monitor: answers each requested byte after two cycles
  initial forever begin
    @(negedge clk);
    xfer_ack = 1'b0;
    if (xfer_req) begin
      wait_cnt++;
      if (wait_cnt == 2) begin
        wait_cnt = 0;
        xfer_rx = (card_dly >= 0 && ack_idx == card_dly + 6) ? card_val : 8'hFF;
        ack_idx++;
        xfer_ack = 1'b1;
        checks++;
        if (expq.size() == 0) begin
          errors++;
          $display("FAIL %s: actual byte %0h cs %0b expected no byte", cur_tag, xfer_tx, cs_n);
        end else begin
          logic [8:0] e;
          e = expq.pop_front();
          if ({cs_n, xfer_tx} !== e) begin
            errors++;
            $display("FAIL %s: actual cs/byte %0h expected %0h", cur_tag, {cs_n, xfer_tx}, e);
          end
        end
      end
    end else wait_cnt = 0;
  end

  task automatic wait_done(input string tag);
    int n = 0;
    while (!done && n < 30000) begin @(negedge clk); n++; end
    if (!done) check({tag, " done"}, 0, 1);
  endtask

  task automatic run_cmd(input logic [5:0] idx, input logic [31:0] arg,
                         input logic ovr, input logic [7:0] ovr_v,
                         input logic hold, input int dly, input logic [7:0] val,
                         input string tag);
    int npoll;
    cur_tag = tag;
    card_dly = dly;
    card_val = val;
    ack_idx = 0;
    expq.push_back({1'b0, 2'b01, idx});
    expq.push_back({1'b0, arg[31:24]});
    expq.push_back({1'b0, arg[23:16]});
    expq.push_back({1'b0, arg[15:8]});
    expq.push_back({1'b0, arg[7:0]});
    expq.push_back({1'b0, ovr ? ovr_v : 8'h95});
    npoll = (dly >= 0) ? dly + 1 : LIMIT;
    for (int i = 0; i < npoll; i++) expq.push_back({1'b0, 8'hFF});
    if (!(hold && dly >= 0)) expq.push_back({1'b1, 8'hFF});
    @(negedge clk);
    cmd_idx = idx; cmd_arg = arg; crc_sel = ovr; crc_val = ovr_v; hold_sel = hold;
    cmd_req = 1'b1;
    @(negedge clk);
    cmd_req = 1'b0;
    check({tag, " cs low before first byte"}, {31'd0, cs_n}, 0);
    check({tag, " no request in setup cycle"}, {31'd0, xfer_req}, 0);
    wait_done(tag);
    check({tag, " resp"}, {24'd0, resp}, (dly >= 0) ? {24'd0, val} : 32'hFF);
    check({tag, " timed_out"}, {31'd0, timed_out}, (dly >= 0) ? 0 : 1);
    check({tag, " cs after done"}, {31'd0, cs_n}, (hold && dly >= 0) ? 0 : 1);
    check({tag, " all bytes seen"}, expq.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all): actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11 cs_n", {31'd0, cs_n}, 1);
    check("R11 xfer_req", {31'd0, xfer_req}, 0);
    check("R11 busy", {31'd0, busy}, 0);
    check("R11 done", {31'd0, done}, 0);
    rst_n = 1'b1;

    run_cmd(6'd0, 32'h0, 1'b0, 8'h00, 1'b0, 0, 8'h01, "R1 R3 R5 R7 idx0");
    run_cmd(6'd17, 32'h12345678, 1'b0, 8'h00, 1'b0, 3, 8'h00, "R2 R5 R7 delayed reply");
    run_cmd(6'd8, 32'h000001AA, 1'b1, 8'h87, 1'b0, 1, 8'h05, "R3 override");
    run_cmd(6'd63, 32'hFFFFFFFF, 1'b0, 8'h00, 1'b0, 0, 8'h7F, "R1 R5 all flags");
    run_cmd(6'd41, 32'h40000000, 1'b0, 8'h00, 1'b0, -1, 8'h00, "R6 R7 timeout");

    run_cmd(6'd9, 32'h0, 1'b0, 8'h00, 1'b1, 2, 8'h00, "R8 hold");
    repeat (12) @(negedge clk);
    check("R8 held cs stays low", {31'd0, cs_n}, 0);
    check("R8 held not busy", {31'd0, busy}, 0);
    check("R8 held no byte", expq.size(), 0);
    cur_tag = "R8 release";
    expq.push_back({1'b1, 8'hFF});
    hold_end = 1'b1;
    @(negedge clk);
    hold_end = 1'b0;
    wait_done("R8 release");
    check("R8 release cs high", {31'd0, cs_n}, 1);
    check("R8 release one byte", expq.size(), 0);

    run_cmd(6'd9, 32'h0, 1'b0, 8'h00, 1'b1, -1, 8'h00, "R9 hold timeout");

    fork
      run_cmd(6'd24, 32'h00000200, 1'b0, 8'h00, 1'b0, 1, 8'h00, "R10 ignore req");
      begin
        repeat (6) @(negedge clk);
        cmd_idx = 6'd55; cmd_arg = 32'hDEADBEEF; cmd_req = 1'b1;
        @(negedge clk);
        cmd_req = 1'b0;
      end
    join
    repeat (20) @(negedge clk);
    check("R10 no second frame", expq.size(), 0);
    check("R10 idle after", {31'd0, busy}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule